// File: doc/BRIEF.md
# Configurable SPI Master

This block is the master end of a synchronous serial link. One start pulse runs one word across the link. While the word is moving, the block drives the serial clock and the data out, and it captures the data in. It lowers exactly one of several active-low select lines for the word. It raises `done` for one cycle when the word has finished, and the received word is then present on `rx_word`.

Each start pulse carries the settings for that word:

- the clock mode, in any of the four combinations of polarity and phase;
- the bit order;
- the word length, from one bit up to the parameterised maximum;
- the slave index;
- a divider that sets the serial half-period in system clocks.

In three-wire operation the master shares one data line with the slave. The word is then either transmit-only, with the output enabled, or receive-only, with the output released and the shared pin sampled. The pad's output enable is brought out, so the tristate buffer sits outside the block.

Top module: `spim_master`

## Requirements
- R1: `mode[1]` is the clock polarity and `mode[0]` is the clock phase. `sck` rests at the polarity level whenever no word is in progress. The first edge of each bit moves `sck` away from that level.
- R2: With phase 0, the first bit is on `sdo` in the same cycle the select line falls. Both sides sample on the first edge of each bit, and `sdo` changes on the second edge.
- R3: With phase 1, `sdo` changes on the first edge of each bit, and both sides sample on the second edge.
- R4: A word of N bits produces exactly 2N `sck` transitions. `sck` holds still while all select lines are high.
- R5: While a word is in progress, only the line of `cs_n` picked by `cs_sel` is low. Outside a word, all lines are high.
- R6: The half-period is `clk_div`+1 system clocks. The first `sck` edge comes `clk_div`+1 cycles after `cs_n` falls. `cs_n` rises one half-period after the last edge, so a word holds its select line low for (2N+1)(`clk_div`+1) cycles.
- R7: With `lsb_first`=0, bit N-1 of the word goes first in both directions. With `lsb_first`=1, bit 0 goes first in both directions.
- R8: `word_len` gives N, from 1 to `MAX_W`. Transmit bits at position N and above are never sent. Receive bits at position N and above read as zero.
- R9: With `three_wire`=1 and `rx_dir`=0, `sdo_oe` is high for the whole word, `sdo` is low whenever `sdo_oe` is low, and `rx_word` returns zero.
- R10: With `three_wire`=1 and `rx_dir`=1, `sdo_oe` stays low for the whole word and the received bits come from `sdi`.
- R11: `done` is high for exactly one cycle. That cycle is the one in which `cs_n` returns high, and `rx_word` already holds the new word in it. `busy` is high from the cycle after an accepted start until that cycle.
- R12: A `start` that arrives while `busy` is high is ignored. The running word keeps its settings, and no second word follows it.
- R13: After reset, `cs_n` is all ones and `sck`, `sdo`, `sdo_oe`, `done`, `busy` and `rx_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts one word when the block is idle |
| tx_word | input | MAX_W | Word to transmit |
| word_len | input | LEN_W | Number of bits in the word (1 to MAX_W) |
| mode | input | 2 | Bit 1 is the clock polarity, bit 0 is the clock phase |
| lsb_first | input | 1 | 1 sends and receives bit 0 first |
| three_wire | input | 1 | Shares a single data line between master and slave |
| rx_dir | input | 1 | In three-wire operation, 1 makes the word receive-only |
| cs_sel | input | SEL_W | Index of the slave to select |
| clk_div | input | DIV_W | Serial half-period minus one, in system clocks |
| sdi | input | 1 | Serial data in (the shared pin in three-wire operation) |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pad |
| cs_n | output | NUM_CS | Active-low select lines, one per slave |
| rx_word | output | MAX_W | Last received word |
| done | output | 1 | One-cycle pulse at the end of a word |
| busy | output | 1 | A word is in progress |

## Verification
On every cycle, the assertions check the following:

- at most one select line is low;
- `sck` does not move while no slave is selected;
- `done` lasts one cycle and coincides with the select line rising;
- the output enable stays low during a three-wire receive;
- `sdo` is quiet while it is not enabled;
- the divider count stays in range;
- a start during a word leaves the select lines alone.

Only the bench's scenarios can show the rest. A model slave, driven by the bench, checks that the bits arrive in the right order on the right edge for each clock mode, bit order and length. It also checks that unused high bits are masked, that the edge count and the half-period timing are correct, and that the select line picks the right slave.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } spim_state_e;

  typedef struct packed {
    logic cpha;
    logic three_wire;
    logic rx_dir;
  } spim_cfg_t;

endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (!run || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  // R6
  div_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= half_div));

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath #(
  parameter int MAX_W = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MAX_W-1:0] ld_word,
  input  logic [LEN_W-1:0] ld_len,
  input  logic             ld_lsb,
  input  logic             ld_cpha,
  input  logic             ld_oe,
  input  logic             ld_rx_en,
  input  logic             drive_en,
  input  logic [LEN_W-1:0] drive_idx,
  input  logic             sample_en,
  input  logic [LEN_W-1:0] sample_idx,
  input  logic             sdi,
  input  logic             finish,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [MAX_W-1:0] rx_word
);

  localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;

  logic [MAX_W-1:0] tx_q;
  logic [MAX_W-1:0] rx_q;
  logic [LEN_W-1:0] len_q;
  logic             lsb_q;
  logic             rx_en_q;

  function automatic logic [IDX_W-1:0] map_pos(input logic [LEN_W-1:0] seq,
                                               input logic [LEN_W-1:0] n,
                                               input logic             lsb);
    logic [LEN_W-1:0] p;
    p = lsb ? seq : (n - seq - LEN_W'(1));
    return IDX_W'(p);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_q    <= '0;
      len_q   <= '0;
      lsb_q   <= 1'b0;
      rx_en_q <= 1'b0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      rx_word <= '0;
    end else if (load) begin
      tx_q    <= ld_word;
      rx_q    <= '0;
      len_q   <= ld_len;
      lsb_q   <= ld_lsb;
      rx_en_q <= ld_rx_en;
      sdo_oe  <= ld_oe;
      sdo     <= ld_oe && !ld_cpha && ld_word[map_pos('0, ld_len, ld_lsb)];
    end else begin
      if (drive_en && sdo_oe)
        sdo <= tx_q[map_pos(drive_idx, len_q, lsb_q)];
      if (sample_en && rx_en_q)
        rx_q[map_pos(sample_idx, len_q, lsb_q)] <= sdi;
      if (finish) begin
        rx_word <= rx_q;
        sdo     <= 1'b0;
        sdo_oe  <= 1'b0;
      end
    end
  end

  // R9
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);

endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int MAX_W  = 32,
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(MAX_W + 1),
  parameter int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MAX_W-1:0]  tx_word,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [1:0]        mode,
  input  logic              lsb_first,
  input  logic              three_wire,
  input  logic              rx_dir,
  input  logic [SEL_W-1:0]  cs_sel,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [NUM_CS-1:0] cs_n,
  output logic [MAX_W-1:0]  rx_word,
  output logic              done,
  output logic              busy
);

  spim_state_e      state_q;
  spim_cfg_t        cfg_q;
  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W:0]   edge_q;

  logic [NUM_CS-1:0] sel_dec;
  logic              accept, run, tick, xfer_tick, finish;
  logic              leading, last_edge;
  logic [LEN_W-1:0]  bit_idx, next_idx, drive_idx;
  logic              drive_en, sample_en;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign sel_dec[g] = (cs_sel == SEL_W'(g));
  end

  assign run       = (state_q != ST_IDLE);
  assign busy      = run;
  assign accept    = start && (state_q == ST_IDLE);
  assign xfer_tick = tick && (state_q == ST_XFER);
  assign finish    = tick && (state_q == ST_TAIL);

  assign leading   = ~edge_q[0];
  assign bit_idx   = edge_q[LEN_W:1];
  assign next_idx  = bit_idx + LEN_W'(1);
  assign last_edge = (edge_q == ({len_q, 1'b0} - (LEN_W+1)'(1)));

  assign drive_en  = xfer_tick &&
                     (cfg_q.cpha ? leading : (!leading && (next_idx < len_q)));
  assign drive_idx = cfg_q.cpha ? bit_idx : next_idx;
  assign sample_en = xfer_tick && (leading ^ cfg_q.cpha);

  spim_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .half_div (div_q),
    .tick     (tick)
  );

  spim_datapath #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .ld_word    (tx_word),
    .ld_len     (word_len),
    .ld_lsb     (lsb_first),
    .ld_cpha    (mode[0]),
    .ld_oe      (!(three_wire && rx_dir)),
    .ld_rx_en   (!three_wire || rx_dir),
    .drive_en   (drive_en),
    .drive_idx  (drive_idx),
    .sample_en  (sample_en),
    .sample_idx (bit_idx),
    .sdi        (sdi),
    .finish     (finish),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .rx_word    (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      len_q   <= '0;
      div_q   <= '0;
      edge_q  <= '0;
      sck     <= 1'b0;
      cs_n    <= '1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            cfg_q   <= '{cpha: mode[0], three_wire: three_wire, rx_dir: rx_dir};
            len_q   <= word_len;
            div_q   <= clk_div;
            edge_q  <= '0;
            sck     <= mode[1];
            cs_n    <= ~sel_dec;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (tick) begin
            sck    <= ~sck;
            edge_q <= edge_q + 1'b1;
            if (last_edge)
              state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n    <= '1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (&cs_n && $past(&cs_n)) |-> $stable(sck));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (&cs_n && !$past(&cs_n)));

  // R10
  rx_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cfg_q.three_wire && cfg_q.rx_dir) |-> !sdo_oe);

  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && start) |=> $stable(cs_n));

endmodule

// File: tb/spim_master_tb.sv
`timescale 1ns/1ps
module spim_master_tb;

  localparam int MAX_W  = 32;
  localparam int NUM_CS = 4;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 6;
  localparam int SEL_W  = 2;

  typedef struct packed {
    logic [1:0]  mode;
    logic        lsb;
    logic        tw;
    logic        rxd;
    logic [5:0]  len;
    logic [7:0]  div;
    logic [1:0]  sel;
    logic [31:0] tx;
    logic [31:0] reply;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 6'd8,  8'd1, 2'd0, 32'h000000A5, 32'h0000003C},
    '{2'd1, 1'b0, 1'b0, 1'b0, 6'd8,  8'd0, 2'd1, 32'h00000096, 32'h000000C3},
    '{2'd2, 1'b1, 1'b0, 1'b0, 6'd12, 8'd2, 2'd2, 32'h00000ABC, 32'h000005A3},
    '{2'd3, 1'b1, 1'b0, 1'b0, 6'd20, 8'd1, 2'd3, 32'hFFF12345, 32'hDEA98765},
    '{2'd0, 1'b1, 1'b0, 1'b0, 6'd16, 8'd3, 2'd0, 32'h00001234, 32'h00008001},
    '{2'd3, 1'b0, 1'b0, 1'b0, 6'd32, 8'd0, 2'd1, 32'hDEADBEEF, 32'h13579BDF},
    '{2'd1, 1'b0, 1'b1, 1'b0, 6'd8,  8'd1, 2'd2, 32'h0000005A, 32'h000000FF},
    '{2'd2, 1'b0, 1'b1, 1'b1, 6'd12, 8'd1, 2'd3, 32'h00000777, 32'h00000A5C},
    '{2'd0, 1'b0, 1'b0, 1'b0, 6'd1,  8'd0, 2'd0, 32'h00000001, 32'h00000001}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [MAX_W-1:0]  tx_word = '0;
  logic [LEN_W-1:0]  word_len = '0;
  logic [1:0]        mode = '0;
  logic              lsb_first = 1'b0;
  logic              three_wire = 1'b0;
  logic              rx_dir = 1'b0;
  logic [SEL_W-1:0]  cs_sel = '0;
  logic [DIV_W-1:0]  clk_div = '0;
  logic              sdi;
  logic              sck, sdo, sdo_oe, done, busy;
  logic [NUM_CS-1:0] cs_n;
  logic [MAX_W-1:0]  rx_word;

  vec_t        cur = '0;
  logic        slv_out = 1'b0;
  int          slv_edges = 0;
  logic [31:0] slv_cap = '0;
  logic [3:0]  cs_seen = '1;
  logic        oe_hi = 1'b0;
  logic        cs_any;
  int          checks = 0;
  int          fails = 0;

  assign cs_any = ~&cs_n;
  assign sdi    = (cur.tw && sdo_oe) ? sdo : slv_out;

  always #10 clk = ~clk;

  spim_master #(.MAX_W(MAX_W), .NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .word_len(word_len),
    .mode(mode), .lsb_first(lsb_first), .three_wire(three_wire), .rx_dir(rx_dir),
    .cs_sel(cs_sel), .clk_div(clk_div), .sdi(sdi), .sck(sck), .sdo(sdo),
    .sdo_oe(sdo_oe), .cs_n(cs_n), .rx_word(rx_word), .done(done), .busy(busy)
  );

  function automatic int seq_pos(input int b, input int n, input logic lsb);
    return lsb ? b : (n - 1 - b);
  endfunction

  function automatic logic [31:0] len_mask(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  // Model slave: outputs reply bits and captures sdo on the edges the mode defines
  initial begin
    forever begin
      @(posedge cs_any);
      #1;
      slv_edges = 0;
      slv_cap   = '0;
      cs_seen   = cs_n;
      oe_hi     = sdo_oe;
      begin
        int bo, bi;
        logic lead;
        bo = 0;
        bi = 0;
        if (!cur.mode[0]) begin
          slv_out = cur.reply[seq_pos(0, int'(cur.len), cur.lsb)];
          bo = 1;
        end
        while (cs_any) begin
          @(sck or cs_any);
          if (!cs_any) break;
          slv_edges++;
          if (sdo_oe) oe_hi = 1'b1;
          lead = (sck != cur.mode[1]);
          if (lead ^ cur.mode[0]) begin
            if (bi < int'(cur.len)) slv_cap[seq_pos(bi, int'(cur.len), cur.lsb)] = sdo;
            bi++;
          end else if (bo < int'(cur.len)) begin
            slv_out = cur.reply[seq_pos(bo, int'(cur.len), cur.lsb)];
            bo++;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cur        = v;
    tx_word    = v.tx;
    word_len   = v.len;
    mode       = v.mode;
    lsb_first  = v.lsb;
    three_wire = v.tw;
    rx_dir     = v.rxd;
    cs_sel     = v.sel;
    clk_div    = v.div;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(cs_n == 4'hF && !sck && !sdo && !sdo_oe && !done && !busy && rx_word == '0,
        "R13 reset", {cs_n, sck, sdo, sdo_oe, done, busy, rx_word}, {4'hF, 37'd0});
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      logic [31:0] m, exp_rx;
      v = VECS[k];
      apply(v);
      pulse_start();
      wait_done(seen);
      chk(seen, "R11 done seen", seen, 1);
      m      = len_mask(int'(v.len));
      exp_rx = (v.tw && !v.rxd) ? 32'd0 : (v.reply & m);
      if (v.tw && !v.rxd)
        chk(rx_word == exp_rx, "R9 tx-only rx zero", rx_word, exp_rx);
      else if (v.lsb)
        chk(rx_word == exp_rx, "R7 lsb-first rx", rx_word, exp_rx);
      else if (v.mode[0])
        chk(rx_word == exp_rx, "R3 phase1 rx", rx_word, exp_rx);
      else
        chk(rx_word == exp_rx, "R2 phase0 rx", rx_word, exp_rx);
      if (!(v.tw && v.rxd))
        chk(slv_cap == (v.tx & m), "R8 sent bits", slv_cap, v.tx & m);
      chk(slv_edges == 2 * int'(v.len), "R4 edge count", slv_edges, 2 * int'(v.len));
      chk(cs_seen == ~(4'd1 << v.sel), "R5 select line", cs_seen, ~(4'd1 << v.sel));
      chk(sck == v.mode[1], "R1 idle level", sck, v.mode[1]);
      if (v.tw && v.rxd)
        chk(!oe_hi, "R10 oe low on receive", oe_hi, 0);
      if (v.tw && !v.rxd)
        chk(oe_hi, "R9 oe high on transmit", oe_hi, 1);
      repeat (2) @(negedge clk);
    end

    // R6 timing, R2 first bit, R11 done/busy
    begin
      int cnt;
      vec_t v;
      v = '{2'd0, 1'b0, 1'b0, 1'b0, 6'd8, 8'd2, 2'd1, 32'h00000081, 32'h00000000};
      apply(v);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(cs_n == 4'b1101 && busy, "R5 select at start", {cs_n, busy}, {4'b1101, 1'b1});
      chk(sdo == 1'b1, "R2 first bit before edge", sdo, 1);
      cnt = 0;
      while (sck == 1'b0 && cnt < 100) begin
        @(negedge clk);
        cnt++;
      end
      chk(cnt == 3, "R6 first edge delay", cnt, 3);
      while (cs_any && cnt < 200) begin
        @(negedge clk);
        cnt++;
      end
      chk(cnt == 51, "R6 select low time", cnt, 51);
      chk(done && !busy, "R11 done with select rise", {done, busy}, 2'b10);
      @(negedge clk);
      chk(!done, "R11 done one cycle", done, 0);
    end

    // R12 start during a word is ignored
    begin
      vec_t v;
      v = '{2'd3, 1'b0, 1'b0, 1'b0, 6'd8, 8'd1, 2'd0, 32'h0000003C, 32'h00000055};
      apply(v);
      pulse_start();
      repeat (6) @(negedge clk);
      tx_word = 32'h000000FF;
      cs_sel  = 2'd3;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      wait_done(seen);
      chk(slv_cap == 32'h3C, "R12 word unchanged", slv_cap, 32'h3C);
      chk(cs_seen == 4'b1110, "R12 select unchanged", cs_seen, 4'b1110);
      repeat (20) @(negedge clk);
      chk(cs_n == 4'hF && !busy, "R12 no second word", {cs_n, busy}, {4'hF, 1'b0});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule